// File: doc/BRIEF.md
# Monitor Channel Sequencer with Averaging

This block drives the conversions of a multi-channel monitoring ADC. It chooses the next channel and waits out an acquisition window counted in ADC clock ticks. It then sends a one-cycle start request with the channel number to the converter, and waits for a done strobe that carries a 16-bit result. The ADC clock is a clock enable divided down from the register clock. Several conversions of the same channel can be accumulated and averaged before the result is published.

The block runs in one of four sequencing modes: a safe loop over the on-chip sensors, a single pass over a channel set, continuous cycling of that set, and single-channel mode with the sequencer off. Each published result comes out with its channel number and an end-of-conversion pulse. An end-of-sequence pulse marks the last channel of a sequence. A busy flag covers every conversion. All configuration comes from input ports and is expected to be held steady while the block runs out of reset.

Top module: `mon_seq_avg`

## Requirements
- R1: With `cfg_mode` = 00 (safe), results cycle endlessly over channels 0, 1, 2 in that order, whatever the enable mask holds. `res_eos` pulses with every channel 2 result.
- R2: With `cfg_mode` = 10 (continuous), results cover the channels whose bits are set in `cfg_chan_en`, in ascending order, and wrap back to the lowest one. `res_eos` pulses with the result of the highest such channel.
- R3: With `cfg_mode` = 01 (one pass), each selected channel is converted once in ascending order, with `res_eos` on the last one. After that no further `adc_start` is issued and `busy` stays low.
- R4: Only channels 0 to 5, 8 and 16 to 31 are ever converted. Channels 6, 7 and 9 to 15 are skipped even when enabled. If no valid channel is enabled in modes 01 or 10, the block behaves as in safe mode.
- R5: With `cfg_mode` = 11 (single), the channel on `cfg_single_chan` is converted repeatedly and `res_eos` never pulses.
- R6: `cfg_avg` codes 00, 01, 10 and 11 average 1, 16, 64 and 256 consecutive conversions of one channel. `res_data` is the floor of their sum divided by that count.
- R7: The ADC tick period is `cfg_clk_div` register-clock cycles, and codes 0, 1 and 2 all give 2. The next `adc_start` is high in the cycle that follows the clock edge lying L·D edges after the edge that samples `adc_done`, where D is the tick period and L is the acquisition length in ticks.
- R8: The acquisition length L is 4 ticks. It is 10 ticks in single mode with `cfg_acq_ext` = 1. In every other mode `cfg_acq_ext` has no effect.
- R9: `busy` rises together with the `adc_start` pulse. It stays high until the edge that samples `adc_done` and is low at all other times.
- R10: `res_valid` pulses for one cycle right after the edge that samples the last `adc_done` of an averaging window. `res_chan` gives the converted channel and `res_data` the averaged value.
- R11: During reset `adc_start`, `busy`, `res_valid`, `res_eos`, `adc_chan`, `res_chan` and `res_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Sequencing mode: 00 safe, 01 one pass, 10 continuous, 11 single |
| cfg_chan_en | input | 32 | One enable bit per channel for modes 01 and 10 |
| cfg_single_chan | input | 5 | Channel converted in single mode |
| cfg_avg | input | 2 | Averaging count: 00 none, 01 16, 10 64, 11 256 |
| cfg_clk_div | input | 8 | ADC clock divide ratio |
| cfg_acq_ext | input | 1 | Extends acquisition by 6 ticks in single mode |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 5 | Channel for the requested conversion |
| adc_done | input | 1 | One-cycle conversion complete strobe |
| adc_result | input | 16 | Conversion result, valid with adc_done |
| res_valid | output | 1 | End-of-conversion pulse for a published result |
| res_chan | output | 5 | Channel of the published result |
| res_data | output | 16 | Averaged result |
| res_eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | High while a conversion is in flight |

## Verification
The assertions assume that the converter answers every start with exactly one done strobe, and never strobes done while no conversion is outstanding. They also assume that configuration stays constant between resets. The bench's ADC stub returns one done, one to four cycles after each start, with a random result. The bench applies each configuration only while reset is held, and reconfigures only through a fresh reset.

// File: rtl/mon_seq_pkg.sv
package mon_seq_pkg;

   localparam logic [1:0] MODE_SAFE   = 2'b00;
   localparam logic [1:0] MODE_ONCE   = 2'b01;
   localparam logic [1:0] MODE_LOOP   = 2'b10;
   localparam logic [1:0] MODE_SINGLE = 2'b11;

   // channels that may be converted: 0..5, 8, 16..31
   localparam logic [31:0] CHAN_OK  = 32'hFFFF_013F;
   // on-chip sensor loop used by safe mode and the empty-set fallback
   localparam logic [31:0] SAFE_SET = 32'h0000_0007;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_CONV = 2'd2,
      ST_HALT = 2'd3
   } mon_state_e;

   function automatic logic [3:0] avg_shift(input logic [1:0] code);
      case (code)
         2'b01:   return 4'd4;
         2'b10:   return 4'd6;
         2'b11:   return 4'd8;
         default: return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/mon_clk_div.sv
module mon_clk_div #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [DW-1:0] ratio,
   output logic          tick
);
   localparam logic [DW-1:0] MIN_DIV = DW'(2);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("mon_clk_div: DW must be at least 2");
      end
   endgenerate

   logic [DW-1:0] lim;
   logic [DW-1:0] cnt;

   assign lim  = (ratio < MIN_DIV) ? MIN_DIV : ratio;
   assign tick = (cnt == lim - DW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr || tick) cnt <= '0;
      else                       cnt <= cnt + DW'(1);
   end

   // the divide ratio is never below two, so ticks never touch
   p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr) |=> !tick);

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ratio) |-> (cnt <= lim));

endmodule

// File: rtl/mon_chan_pick.sv
module mon_chan_pick
   import mon_seq_pkg::*;
#(
   parameter int NCH = 32,
   parameter int CW  = 5
) (
   input  logic [1:0]     mode,
   input  logic [NCH-1:0] chan_en,
   input  logic [CW-1:0]  cur,
   output logic [CW-1:0]  first_ch,
   output logic [CW-1:0]  next_ch,
   output logic           last
);
   generate
      if (NCH != (1 << CW) || NCH > 32) begin : g_bad_nch
         $error("mon_chan_pick: NCH must equal 2**CW and be at most 32");
      end
   endgenerate

   logic [NCH-1:0] eff;
   logic [NCH-1:0] seq_set;

   for (genvar i = 0; i < NCH; i++) begin : g_eff
      assign eff[i] = chan_en[i] & CHAN_OK[i];
   end

   assign seq_set = (mode == MODE_SAFE || eff == '0) ? NCH'(SAFE_SET) : eff;

   always_comb begin
      first_ch = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (seq_set[i]) first_ch = CW'(i);
      end
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      next_ch = first_ch;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (seq_set[i] && (i > int'(cur))) begin
            next_ch = CW'(i);
            found   = 1'b1;
         end
      end
      last = !found;
   end

endmodule

// File: rtl/mon_avg_acc.sv
module mon_avg_acc
   import mon_seq_pkg::*;
#(
   parameter int RW     = 16,
   parameter int MAXLOG = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sample_en,
   input  logic [RW-1:0] sample,
   input  logic [1:0]    avg_code,
   output logic          last_sample,
   output logic [RW-1:0] avg_out
);
   localparam int AW = RW + MAXLOG;

   generate
      if (MAXLOG != 8) begin : g_bad_log
         $error("mon_avg_acc: averaging codes need MAXLOG of 8");
      end
      if (RW < 10) begin : g_bad_rw
         $error("mon_avg_acc: result width below 10 bits");
      end
   endgenerate

   logic [AW-1:0]     acc;
   logic [AW-1:0]     sum_w;
   logic [MAXLOG-1:0] cnt;
   logic [MAXLOG-1:0] lim;
   logic [3:0]        sh;

   assign sh          = avg_shift(avg_code);
   assign lim         = MAXLOG'((32'd1 << sh) - 32'd1);
   assign last_sample = (cnt == lim);
   assign sum_w       = acc + AW'(sample);
   assign avg_out     = RW'(sum_w >> sh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         cnt <= '0;
      end else if (sample_en) begin
         if (last_sample) begin
            acc <= '0;
            cnt <= '0;
         end else begin
            acc <= sum_w;
            cnt <= cnt + MAXLOG'(1);
         end
      end
   end

   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(avg_code) |-> (cnt <= lim));

   p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && last_sample) |=> (acc == '0));

endmodule

// File: rtl/mon_seq_avg.sv
module mon_seq_avg
   import mon_seq_pkg::*;
#(
   parameter int NCH       = 32,
   parameter int CW        = 5,
   parameter int RW        = 16,
   parameter int DW        = 8,
   parameter int MAXLOG    = 8,
   parameter int ACQ_BASE  = 4,
   parameter int ACQ_EXTRA = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     cfg_mode,
   input  logic [NCH-1:0] cfg_chan_en,
   input  logic [CW-1:0]  cfg_single_chan,
   input  logic [1:0]     cfg_avg,
   input  logic [DW-1:0]  cfg_clk_div,
   input  logic           cfg_acq_ext,
   output logic           adc_start,
   output logic [CW-1:0]  adc_chan,
   input  logic           adc_done,
   input  logic [RW-1:0]  adc_result,
   output logic           res_valid,
   output logic [CW-1:0]  res_chan,
   output logic [RW-1:0]  res_data,
   output logic           res_eos,
   output logic           busy
);
   localparam int AQW = $clog2(ACQ_BASE + ACQ_EXTRA + 1);

   generate
      if (ACQ_BASE < 1) begin : g_bad_acq
         $error("mon_seq_avg: acquisition needs at least one tick");
      end
   endgenerate

   mon_state_e    state;
   logic [CW-1:0] cur_ch;
   logic [AQW-1:0] acq_cnt;
   logic [AQW-1:0] acq_len;
   logic          tick;
   logic          div_clr;
   logic          single_ok;
   logic          is_single;
   logic [CW-1:0] first_ch;
   logic [CW-1:0] next_ch;
   logic          seq_last;
   logic          sample_en;
   logic          last_sample;
   logic [RW-1:0] avg_out;

   assign is_single = (cfg_mode == MODE_SINGLE);
   assign single_ok = CHAN_OK[cfg_single_chan];
   assign acq_len   = AQW'(ACQ_BASE) + ((is_single && cfg_acq_ext) ? AQW'(ACQ_EXTRA) : '0);
   assign sample_en = (state == ST_CONV) && adc_done;
   assign div_clr   = (state == ST_IDLE) || sample_en;

   mon_clk_div #(.DW(DW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (div_clr),
      .ratio (cfg_clk_div),
      .tick  (tick)
   );

   mon_chan_pick #(.NCH(NCH), .CW(CW)) u_pick (
      .mode     (cfg_mode),
      .chan_en  (cfg_chan_en),
      .cur      (cur_ch),
      .first_ch (first_ch),
      .next_ch  (next_ch),
      .last     (seq_last)
   );

   mon_avg_acc #(.RW(RW), .MAXLOG(MAXLOG)) u_avg (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_en   (sample_en),
      .sample      (adc_result),
      .avg_code    (cfg_avg),
      .last_sample (last_sample),
      .avg_out     (avg_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_ch    <= '0;
         acq_cnt   <= '0;
         adc_start <= 1'b0;
         adc_chan  <= '0;
         busy      <= 1'b0;
         res_valid <= 1'b0;
         res_eos   <= 1'b0;
         res_chan  <= '0;
         res_data  <= '0;
      end else begin
         adc_start <= 1'b0;
         res_valid <= 1'b0;
         res_eos   <= 1'b0;
         case (state)
            ST_IDLE: begin
               acq_cnt <= '0;
               if (is_single) begin
                  if (single_ok) begin
                     cur_ch <= cfg_single_chan;
                     state  <= ST_ACQ;
                  end
               end else begin
                  cur_ch <= first_ch;
                  state  <= ST_ACQ;
               end
            end
            ST_ACQ: begin
               if (tick) begin
                  if (acq_cnt == acq_len - AQW'(1)) begin
                     acq_cnt   <= '0;
                     adc_start <= 1'b1;
                     adc_chan  <= cur_ch;
                     busy      <= 1'b1;
                     state     <= ST_CONV;
                  end else begin
                     acq_cnt <= acq_cnt + AQW'(1);
                  end
               end
            end
            ST_CONV: begin
               if (adc_done) begin
                  busy  <= 1'b0;
                  state <= ST_ACQ;
                  if (last_sample) begin
                     res_valid <= 1'b1;
                     res_chan  <= cur_ch;
                     res_data  <= avg_out;
                     res_eos   <= !is_single && seq_last;
                     if (is_single) begin
                        cur_ch <= cfg_single_chan;
                        if (!single_ok) state <= ST_IDLE;
                     end else if (seq_last && cfg_mode == MODE_ONCE) begin
                        state <= ST_HALT;
                     end else begin
                        cur_ch <= next_ch;
                     end
                  end
               end
            end
            default: begin
               if (cfg_mode != MODE_ONCE) state <= ST_IDLE;
            end
         endcase
      end
   end

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> busy);

   p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && adc_done) |=> !busy);

   p_eos_with_eoc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_eos |-> res_valid);

   p_start_chan_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> CHAN_OK[adc_chan]);

   p_single_no_eos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && cfg_mode == MODE_SINGLE) |-> !res_eos);

   p_safe_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && cfg_mode == MODE_SAFE) |-> (res_chan <= CW'(2)));

   p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |-> (!adc_start && !busy));

endmodule

// File: tb/mon_seq_avg_test.sv
module mon_seq_avg_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic [1:0]  cfg_mode, cfg_avg;
   logic [31:0] cfg_chan_en;
   logic [4:0]  cfg_single_chan;
   logic [7:0]  cfg_clk_div;
   logic        cfg_acq_ext;
   logic        adc_done;
   logic [15:0] adc_result;
   logic        adc_start, res_valid, res_eos, busy;
   logic [4:0]  adc_chan, res_chan;
   logic [15:0] res_data;

   mon_seq_avg uut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chan_en(cfg_chan_en),
      .cfg_single_chan(cfg_single_chan), .cfg_avg(cfg_avg), .cfg_clk_div(cfg_clk_div),
      .cfg_acq_ext(cfg_acq_ext), .adc_start(adc_start), .adc_chan(adc_chan),
      .adc_done(adc_done), .adc_result(adc_result), .res_valid(res_valid),
      .res_chan(res_chan), .res_data(res_data), .res_eos(res_eos), .busy(busy)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // channel model from the requirements
   function automatic logic [31:0] seq_set(input int mode, input logic [31:0] en);
      logic [31:0] e = 32'd0;
      for (int i = 0; i < 32; i++)
         if (en[i] && (i <= 5 || i == 8 || i >= 16)) e[i] = 1'b1;
      if (mode == 0 || e == 32'd0) return 32'd7;
      return e;
   endfunction

   function automatic int first_of(input logic [31:0] s);
      for (int i = 0; i < 32; i++) if (s[i]) return i;
      return 0;
   endfunction

   function automatic int next_of(input logic [31:0] s, input int cur);
      for (int i = cur + 1; i < 32; i++) if (s[i]) return i;
      return -1;
   endfunction

   // scenario and stub state
   bit          active = 0, inflight = 0, clr_pending = 0, have_done = 0, first_res = 1, win_bad = 0;
   int          lat = 0, samples = 0, done_cyc = 0, start_cnt = 0, res_cnt = 0, eos_cnt = 0;
   int          win_ch = 0, prev_ch = 0, m_mode = 0, m_single = 0, m_n = 1, m_sh = 0, m_l = 4, m_d = 2;
   logic [31:0] m_set = 32'd7;
   longint      sum = 0;
   string       tag = "R1";

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1;
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (active) begin
         if (clr_pending) begin
            adc_done = 1'b0; clr_pending = 0; inflight = 0;
            chk(busy == 1'b0, "R9", busy, 0);
         end else if (inflight && lat > 0) begin
            lat--;
            if (lat == 0) begin
               adc_result = 16'($urandom);
               adc_done   = 1'b1;
               sum += adc_result;
               samples++;
               done_cyc = cyc; have_done = 1; clr_pending = 1;
               chk(busy == 1'b1, "R9", busy, 1);
            end
         end
         if (adc_start) begin
            if (have_done) chk(cyc == done_cyc + 1 + m_l * m_d, "R7 R8", cyc - done_cyc, 1 + m_l * m_d);
            start_cnt++;
            inflight = 1;
            lat = 1 + int'($urandom % 4);
            if (samples == 0) win_ch = adc_chan;
            else if (adc_chan != 5'(win_ch)) win_bad = 1;
         end
         if (res_valid) begin
            int  exp_ch, n;
            bit  exp_eos;
            if (m_mode == 3) exp_ch = m_single;
            else if (first_res) exp_ch = first_of(m_set);
            else begin
               n = next_of(m_set, prev_ch);
               exp_ch = (n < 0) ? first_of(m_set) : n;
            end
            exp_eos = (m_mode != 3) && (next_of(m_set, exp_ch) < 0);
            chk(res_chan == 5'(exp_ch), tag, res_chan, exp_ch);
            chk(res_eos == exp_eos, tag, res_eos, exp_eos);
            chk(res_data == 16'(sum >> m_sh), "R6", res_data, sum >> m_sh);
            chk(samples == m_n, "R6", samples, m_n);
            chk(!win_bad && win_ch == int'(res_chan), "R10", win_ch, res_chan);
            prev_ch = exp_ch; first_res = 0;
            sum = 0; samples = 0; win_bad = 0;
            res_cnt++;
            if (res_eos) eos_cnt++;
         end
      end
   end

   task automatic run(input int mode, input logic [31:0] en, input int single, input int avg,
                      input int div, input bit ext, input int nres, input string t);
      @(negedge clk);
      active = 0; rst_n = 1'b0; adc_done = 1'b0;
      cfg_mode = 2'(mode); cfg_chan_en = en; cfg_single_chan = 5'(single);
      cfg_avg = 2'(avg); cfg_clk_div = 8'(div); cfg_acq_ext = ext;
      m_mode = mode; m_single = single; m_set = seq_set(mode, en);
      m_sh = (avg == 0) ? 0 : (avg == 1) ? 4 : (avg == 2) ? 6 : 8;
      m_n = 1 << m_sh;
      m_d = (div < 2) ? 2 : div;
      m_l = (mode == 3 && ext) ? 10 : 4;
      inflight = 0; clr_pending = 0; have_done = 0; first_res = 1; win_bad = 0;
      lat = 0; samples = 0; start_cnt = 0; res_cnt = 0; eos_cnt = 0; sum = 0; tag = t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; active = 1;
      while (res_cnt < nres) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; adc_done = 1'b0; adc_result = '0;
      cfg_mode = 2'b00; cfg_chan_en = '0; cfg_single_chan = '0;
      cfg_avg = 2'b00; cfg_clk_div = '0; cfg_acq_ext = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(adc_start == 0 && busy == 0 && res_valid == 0 && res_eos == 0, "R11",
          {adc_start, busy, res_valid, res_eos}, 0);
      chk(adc_chan == 0 && res_chan == 0 && res_data == 0, "R11", res_data, 0);

      // R1 safe mode ignores the mask
      run(0, 32'hFFFF_0000, 0, 0, 0, 1'b0, 9, "R1");
      // R2 continuous over a random mask with invalid bits forced in, R4 skip
      run(2, $urandom | 32'h0000_02C0, 0, 1, 5, 1'b1, 22, "R2");
      // R4 only invalid channels enabled: safe fallback
      run(2, 32'h0000_FEC0, 0, 0, 0, 1'b0, 6, "R4");
      // R3 one pass, then silence
      begin
         logic [31:0] en;
         int          nch;
         en  = $urandom | 32'h0001_0001;
         nch = $countones(seq_set(1, en));
         run(1, en, 0, 2, 1, 1'b0, nch, "R3");
         repeat (3000) @(negedge clk);
         chk(res_cnt == nch && eos_cnt == 1, "R3", res_cnt, nch);
         chk(start_cnt == nch * 64, "R3", start_cnt, nch * 64);
         chk(busy == 1'b0 && adc_start == 1'b0, "R3", busy, 0);
      end
      // R5 single channel with extended acquisition, heaviest averaging
      run(3, 32'd0, 17, 3, 3, 1'b1, 2, "R5");
      // R5 single channel, calibration request channel, no extension, slow clock
      run(3, 32'hFFFF_FFFF, 8, 0, 200, 1'b0, 4, "R5");
      // R2 continuous with extension bit set but ignored (R8), divide code 2
      run(2, 32'h8001_0030, 0, 0, 2, 1'b1, 8, "R2");

      active = 0;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule